// File: doc/BRIEF.md
# Parity-Converting DMA Buffer

This block is a word-wide staging buffer between a host bus and an 8-bit peripheral bus. It works in one direction at a time. In the send direction the host writes 32-bit words that carry a single even parity bit. The buffer checks that bit as each word arrives. The peripheral side then reads the words back one byte at a time, and every byte it receives carries a freshly made odd parity bit.

In the receive direction the peripheral writes bytes with odd parity. The buffer checks each byte, packs four of them into a word and stores the word. The host reads whole words, and each word carries a newly generated even parity bit. The storage itself holds no parity, so a fault is only caught where data enters. A parity fault raises a sticky flag for that side, and the data still passes through unchanged.

Usable depth is selectable. By default it is a small compatible depth of 22 words (88 bytes). A size-select input opens the full 134 words (536 bytes). The buffer only takes on a new depth or a new direction when it is completely idle.

Top module: `dma_parity_buf`

## Requirements
- R1: After a synchronous reset, `empty`=1, `full`=0, `count`=0, `size_act`=0 (22-word depth), `dir_act`=0 (send), both error flags are 0 and both read-valid outputs are 0.
- R2: With `size_act`=0 the buffer holds at most 22 words, and with `size_act`=1 at most 134. `full` is 1 exactly when `count` equals that limit. A write offered while full is dropped and leaves `count` unchanged.
- R3: `count` is the number of complete words stored. It changes by at most one per cycle, and `empty` is 1 exactly when it is 0.
- R4: `size_big` is copied to `size_act`, and `dir_rx` to `dir_act`, on a clock edge only when the buffer is idle. Idle means no stored words, no partly packed receive word and no partly sent word. Otherwise both keep their value until the buffer becomes idle.
- R5: In the send direction (`dir_act`=0), an accepted host word whose 32 data bits and parity bit hold an odd number of ones sets `err_host` one cycle later.
- R6: In the send direction, `per_rd_en` with a word stored gives `per_rd_valid`=1 in the next cycle. The byte comes from lane 0 (bits 7:0) first, then lanes 1, 2 and 3. `per_rd_par` makes the byte plus parity hold an odd number of ones. The word leaves storage after its lane-3 byte.
- R7: In the receive direction (`dir_act`=1), accepted peripheral bytes fill lanes 0 to 3 in arrival order, the first byte in bits 7:0. The word is stored on the fourth byte. A byte whose 8 bits plus parity hold an even number of ones sets `err_per` one cycle later.
- R8: In the receive direction, `host_rd_en` with a word stored gives `host_rd_valid`=1 in the next cycle, with the oldest word on `host_rd_data`. `host_rd_par` makes the 32 bits plus parity hold an even number of ones.
- R9: The error flags stay set until `err_clr` is high on a clock edge. A new error on that same edge wins over the clear. Data with a parity error is stored and delivered unchanged.
- R10: A write from the side that does not match `dir_act` is ignored, and so are reads from an empty buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| size_big | input | 1 | Requested depth: 1 selects the full 134 words |
| dir_rx | input | 1 | Requested direction: 1 selects receive |
| err_clr | input | 1 | Clears both error flags |
| host_wr_valid | input | 1 | Host offers a word (send direction) |
| host_wr_data | input | 32 | Host word |
| host_wr_par | input | 1 | Even parity bit of the host word |
| host_rd_en | input | 1 | Host pops a word (receive direction) |
| host_rd_valid | output | 1 | Host read data valid |
| host_rd_data | output | 32 | Word to host |
| host_rd_par | output | 1 | Generated even parity of host_rd_data |
| per_wr_valid | input | 1 | Peripheral offers a byte (receive direction) |
| per_wr_data | input | 8 | Peripheral byte |
| per_wr_par | input | 1 | Odd parity bit of the peripheral byte |
| per_rd_en | input | 1 | Peripheral pops a byte (send direction) |
| per_rd_valid | output | 1 | Peripheral read data valid |
| per_rd_data | output | 8 | Byte to peripheral |
| per_rd_par | output | 1 | Generated odd parity of per_rd_data |
| full | output | 1 | Stored words equal the active depth |
| empty | output | 1 | No complete word stored |
| count | output | 8 | Number of stored words |
| size_act | output | 1 | Active depth select |
| dir_act | output | 1 | Active direction, 1 = receive |
| err_host | output | 1 | Sticky host-side parity error |
| err_per | output | 1 | Sticky peripheral-side parity error |

## Verification
The hardest case to reach is a mode request that arrives while the buffer looks empty but is not idle. This happens when a receive word is only partly packed: `count` and `empty` show nothing stored, yet the direction must not switch. The stimulus writes two bytes, drops `dir_rx` and waits several cycles to show that `dir_act` holds. It then completes the word, reads it back and watches the switch happen one cycle after the read. A size request made while one word is stored at full depth is handled the same way. The full-depth fill takes 134 writes and 536 byte reads, so both the wrap of the storage pointer and the limit at 134 are exercised.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  typedef enum logic {
    DIR_SEND = 1'b0,
    DIR_RECV = 1'b1
  } dir_e;
endpackage

// File: rtl/dpb_store.sv
// Word storage with occupancy tracking; memory written for block-RAM inference.
module dpb_store #(
  parameter int DEPTH  = 134,
  parameter int WIDTH  = 32,
  parameter int CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cap_i,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             rd_en,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= wdata;
    if (rd_en) rdata <= mem[rp_q];
  end

  always_comb begin
    cnt_n = cnt_q;
    if (push && !pop) cnt_n = cnt_q + 1'b1;
    else if (pop && !push) cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      full  <= 1'b0;
      empty <= 1'b1;
    end else begin
      if (push) wp_q <= (wp_q == LAST) ? '0 : wp_q + 1'b1;
      if (pop)  rp_q <= (rp_q == LAST) ? '0 : rp_q + 1'b1;
      cnt_q <= cnt_n;
      full  <= (cnt_n >= cap_i);
      empty <= (cnt_n == '0);
    end
  end

  assign count = cnt_q;
endmodule

// File: rtl/dpb_rx_pack.sv
// Packs peripheral bytes into words, lane 0 first, and checks odd byte parity.
module dpb_rx_pack #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_acc,
  input  logic [LANE_W-1:0]       in_byte,
  input  logic                    in_par,
  output logic [LANES*LANE_W-1:0] word_o,
  output logic                    word_push,
  output logic                    partial,
  output logic                    par_bad
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LW-1:0] TOP = LW'(LANES - 1);

  logic [LW-1:0]     lane_q;
  logic [LANE_W-1:0] hold_q [LANES-1];

  always_ff @(posedge clk) begin
    if (rst) lane_q <= '0;
    else if (in_acc) lane_q <= (lane_q == TOP) ? '0 : lane_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < LANES - 1; g++) begin
      if (in_acc && lane_q == LW'(g)) hold_q[g] <= in_byte;
    end
  end

  for (genvar g = 0; g < LANES - 1; g++) begin : g_hold
    assign word_o[g*LANE_W +: LANE_W] = hold_q[g];
  end
  assign word_o[(LANES-1)*LANE_W +: LANE_W] = in_byte;

  assign word_push = in_acc && (lane_q == TOP);
  assign partial   = (lane_q != '0);
  assign par_bad   = in_acc && !(^{in_byte, in_par});
endmodule

// File: rtl/dpb_tx_lane.sv
// Splits stored words into bytes, lane 0 first, with odd byte parity generated.
module dpb_tx_lane #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    rd_req,
  input  logic [LANES*LANE_W-1:0] word_q,
  output logic                    byte_valid,
  output logic [LANE_W-1:0]       byte_data,
  output logic                    byte_par,
  output logic                    pop,
  output logic                    partial
);
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LW-1:0] TOP = LW'(LANES - 1);

  logic [LW-1:0]     lane_q, sel_q;
  logic [LANE_W-1:0] lane_v [LANES];

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_q     <= '0;
      sel_q      <= '0;
      byte_valid <= 1'b0;
    end else begin
      byte_valid <= rd_req;
      if (rd_req) begin
        sel_q  <= lane_q;
        lane_q <= (lane_q == TOP) ? '0 : lane_q + 1'b1;
      end
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_v[g] = word_q[g*LANE_W +: LANE_W];
  end

  assign byte_data = lane_v[sel_q];
  assign byte_par  = ~^byte_data;
  assign pop       = rd_req && (lane_q == TOP);
  assign partial   = (lane_q != '0);
endmodule

// File: rtl/dma_parity_buf.sv
module dma_parity_buf #(
  parameter int LANES        = 4,
  parameter int LANE_W       = 8,
  parameter int DEPTH_FULL   = 134,
  parameter int DEPTH_COMPAT = 22
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         size_big,
  input  logic                         dir_rx,
  input  logic                         err_clr,
  input  logic                         host_wr_valid,
  input  logic [LANES*LANE_W-1:0]      host_wr_data,
  input  logic                         host_wr_par,
  input  logic                         host_rd_en,
  output logic                         host_rd_valid,
  output logic [LANES*LANE_W-1:0]      host_rd_data,
  output logic                         host_rd_par,
  input  logic                         per_wr_valid,
  input  logic [LANE_W-1:0]            per_wr_data,
  input  logic                         per_wr_par,
  input  logic                         per_rd_en,
  output logic                         per_rd_valid,
  output logic [LANE_W-1:0]            per_rd_data,
  output logic                         per_rd_par,
  output logic                         full,
  output logic                         empty,
  output logic [$clog2(DEPTH_FULL+1)-1:0] count,
  output logic                         size_act,
  output logic                         dir_act,
  output logic                         err_host,
  output logic                         err_per
);
  import dpb_pkg::*;

  localparam int WORD_W = LANES * LANE_W;
  localparam int CNT_W  = $clog2(DEPTH_FULL + 1);
  localparam logic [CNT_W-1:0] CAP_BIG   = CNT_W'(DEPTH_FULL);
  localparam logic [CNT_W-1:0] CAP_SMALL = CNT_W'(DEPTH_COMPAT);

  dir_e              dir_q;
  logic              size_q;
  logic [CNT_W-1:0]  cap;
  logic              host_acc, host_rd_req, per_acc, tx_req;
  logic              push, pop, rd_en, idle;
  logic [WORD_W-1:0] wdata, pack_word, rd_word;
  logic              pack_push, pack_partial, pack_bad;
  logic              tx_pop, tx_partial;
  logic              host_bad;
  logic              hvalid_q;

  assign dir_act  = (dir_q == DIR_RECV);
  assign size_act = size_q;
  assign cap      = size_q ? CAP_BIG : CAP_SMALL;

  // Side gating: only the active direction's writer and reader are heard.
  assign host_acc    = host_wr_valid && (dir_q == DIR_SEND) && !full;
  assign per_acc     = per_wr_valid  && (dir_q == DIR_RECV) && !full;
  assign host_rd_req = host_rd_en    && (dir_q == DIR_RECV) && !empty;
  assign tx_req      = per_rd_en     && (dir_q == DIR_SEND) && !empty;

  assign push  = host_acc || pack_push;
  assign wdata = (dir_q == DIR_RECV) ? pack_word : host_wr_data;
  assign rd_en = host_rd_req || tx_req;
  assign pop   = host_rd_req || tx_pop;

  assign host_bad = host_acc && (^{host_wr_data, host_wr_par});
  assign idle     = empty && !pack_partial && !tx_partial;

  dpb_store #(
    .DEPTH (DEPTH_FULL),
    .WIDTH (WORD_W),
    .CNT_W (CNT_W)
  ) u_store (
    .clk   (clk),
    .rst   (rst),
    .cap_i (cap),
    .push  (push),
    .wdata (wdata),
    .rd_en (rd_en),
    .pop   (pop),
    .rdata (rd_word),
    .count (count),
    .full  (full),
    .empty (empty)
  );

  dpb_rx_pack #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_pack (
    .clk       (clk),
    .rst       (rst),
    .in_acc    (per_acc),
    .in_byte   (per_wr_data),
    .in_par    (per_wr_par),
    .word_o    (pack_word),
    .word_push (pack_push),
    .partial   (pack_partial),
    .par_bad   (pack_bad)
  );

  dpb_tx_lane #(
    .LANES  (LANES),
    .LANE_W (LANE_W)
  ) u_tx (
    .clk        (clk),
    .rst        (rst),
    .rd_req     (tx_req),
    .word_q     (rd_word),
    .byte_valid (per_rd_valid),
    .byte_data  (per_rd_data),
    .byte_par   (per_rd_par),
    .pop        (tx_pop),
    .partial    (tx_partial)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q    <= DIR_SEND;
      size_q   <= 1'b0;
      err_host <= 1'b0;
      err_per  <= 1'b0;
      hvalid_q <= 1'b0;
    end else begin
      if (idle) begin
        size_q <= size_big;
        dir_q  <= dir_rx ? DIR_RECV : DIR_SEND;
      end
      if (host_bad)     err_host <= 1'b1;
      else if (err_clr) err_host <= 1'b0;
      if (pack_bad)     err_per  <= 1'b1;
      else if (err_clr) err_per  <= 1'b0;
      hvalid_q <= host_rd_req;
    end
  end

  assign host_rd_valid = hvalid_q;
  assign host_rd_data  = rd_word;
  assign host_rd_par   = ^rd_word;
endmodule

// File: rtl/dpb_checker.sv
module dpb_checker #(
  parameter int CNT_W        = 8,
  parameter int DEPTH_FULL   = 134,
  parameter int DEPTH_COMPAT = 22,
  parameter int LANE_W       = 8,
  parameter int WORD_W       = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              err_clr,
  input logic              size_act,
  input logic              dir_act,
  input logic              full,
  input logic              empty,
  input logic [CNT_W-1:0]  count,
  input logic              per_rd_valid,
  input logic [LANE_W-1:0] per_rd_data,
  input logic              per_rd_par,
  input logic              host_rd_valid,
  input logic [WORD_W-1:0] host_rd_data,
  input logic              host_rd_par,
  input logic              err_host,
  input logic              err_per
);
  logic [CNT_W-1:0] cap;
  assign cap = size_act ? CNT_W'(DEPTH_FULL) : CNT_W'(DEPTH_COMPAT);

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (empty && !full && count == '0 && !size_act && !dir_act &&
             !err_host && !err_per && !per_rd_valid && !host_rd_valid));

  assert_no_overflow_R2: assert property (@(posedge clk) disable iff (rst)
    count <= cap);

  assert_full_at_cap_R2: assert property (@(posedge clk) disable iff (rst)
    full == (count == cap));

  assert_empty_flag_R3: assert property (@(posedge clk) disable iff (rst)
    empty == (count == '0));

  assert_count_step_R3: assert property (@(posedge clk) disable iff (rst)
    (count == $past(count)) || (count == $past(count) + 1'b1) ||
    (count + 1'b1 == $past(count)));

  assert_mode_hold_R4: assert property (@(posedge clk) disable iff (rst)
    ((size_act != $past(size_act)) || (dir_act != $past(dir_act))) |-> $past(empty));

  assert_tx_odd_R6: assert property (@(posedge clk) disable iff (rst)
    per_rd_valid |-> (^{per_rd_data, per_rd_par}));

  assert_rx_even_R8: assert property (@(posedge clk) disable iff (rst)
    host_rd_valid |-> !(^{host_rd_data, host_rd_par}));

  assert_host_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (err_host && !err_clr) |=> err_host);

  assert_per_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    (err_per && !err_clr) |=> err_per);

  assert_tx_side_R10: assert property (@(posedge clk) disable iff (rst)
    per_rd_valid |-> !dir_act);

  assert_rx_side_R10: assert property (@(posedge clk) disable iff (rst)
    host_rd_valid |-> dir_act);
endmodule

bind dma_parity_buf dpb_checker #(
  .CNT_W        (CNT_W),
  .DEPTH_FULL   (DEPTH_FULL),
  .DEPTH_COMPAT (DEPTH_COMPAT),
  .LANE_W       (LANE_W),
  .WORD_W       (WORD_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .err_clr       (err_clr),
  .size_act      (size_act),
  .dir_act       (dir_act),
  .full          (full),
  .empty         (empty),
  .count         (count),
  .per_rd_valid  (per_rd_valid),
  .per_rd_data   (per_rd_data),
  .per_rd_par    (per_rd_par),
  .host_rd_valid (host_rd_valid),
  .host_rd_data  (host_rd_data),
  .host_rd_par   (host_rd_par),
  .err_host      (err_host),
  .err_per       (err_per)
);

// File: tb/dma_parity_buf_bench.sv
`timescale 1ns/1ps
module dma_parity_buf_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        size_big = 1'b0, dir_rx = 1'b0, err_clr = 1'b0;
  logic        host_wr_valid = 1'b0, host_wr_par = 1'b0, host_rd_en = 1'b0;
  logic [31:0] host_wr_data = '0;
  logic        host_rd_valid, host_rd_par;
  logic [31:0] host_rd_data;
  logic        per_wr_valid = 1'b0, per_wr_par = 1'b0, per_rd_en = 1'b0;
  logic [7:0]  per_wr_data = '0;
  logic        per_rd_valid, per_rd_par;
  logic [7:0]  per_rd_data;
  logic        full, empty, size_act, dir_act, err_host, err_per;
  logic [7:0]  count;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  dma_parity_buf u_dma_parity_buf (
    .clk(clk), .rst(rst), .size_big(size_big), .dir_rx(dir_rx), .err_clr(err_clr),
    .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data), .host_wr_par(host_wr_par),
    .host_rd_en(host_rd_en), .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data),
    .host_rd_par(host_rd_par), .per_wr_valid(per_wr_valid), .per_wr_data(per_wr_data),
    .per_wr_par(per_wr_par), .per_rd_en(per_rd_en), .per_rd_valid(per_rd_valid),
    .per_rd_data(per_rd_data), .per_rd_par(per_rd_par), .full(full), .empty(empty),
    .count(count), .size_act(size_act), .dir_act(dir_act), .err_host(err_host),
    .err_per(err_per)
  );

  function automatic bit even_bit(input logic [31:0] w);
    int n = 0;
    for (int i = 0; i < 32; i++) n += int'(w[i]);
    return bit'(n % 2);
  endfunction

  function automatic bit odd_bit(input logic [7:0] b);
    int n = 0;
    for (int i = 0; i < 8; i++) n += int'(b[i]);
    return bit'((n + 1) % 2);
  endfunction

  function automatic logic [31:0] pat(input int i);
    return 32'h03020100 + 32'h01010101 * i;
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwrite(input logic [31:0] w, input bit p);
    host_wr_valid = 1'b1; host_wr_data = w; host_wr_par = p;
    tick();
    host_wr_valid = 1'b0;
  endtask

  task automatic pwrite(input logic [7:0] b, input bit p);
    per_wr_valid = 1'b1; per_wr_data = b; per_wr_par = p;
    tick();
    per_wr_valid = 1'b0;
  endtask

  task automatic pread(input logic [7:0] exp, input string tag);
    per_rd_en = 1'b1;
    tick();
    per_rd_en = 1'b0;
    chk(per_rd_valid == 1'b1, {tag, " per_rd_valid"}, 32'(per_rd_valid), 1);
    chk(per_rd_data == exp, {tag, " byte"}, 32'(per_rd_data), 32'(exp));
    chk(per_rd_par == odd_bit(exp), {tag, " odd parity"}, 32'(per_rd_par), 32'(odd_bit(exp)));
  endtask

  task automatic pread_word(input logic [31:0] w, input string tag);
    for (int k = 0; k < 4; k++) pread(w[k*8 +: 8], tag);
  endtask

  task automatic hread(input logic [31:0] exp, input string tag);
    host_rd_en = 1'b1;
    tick();
    host_rd_en = 1'b0;
    chk(host_rd_valid == 1'b1, {tag, " host_rd_valid"}, 32'(host_rd_valid), 1);
    chk(host_rd_data == exp, {tag, " word"}, host_rd_data, exp);
    chk(host_rd_par == even_bit(exp), {tag, " even parity"}, 32'(host_rd_par), 32'(even_bit(exp)));
  endtask

  task automatic t_reset();
    chk(empty == 1'b1, "R1 empty", 32'(empty), 1);
    chk(full == 1'b0, "R1 full", 32'(full), 0);
    chk(count == 8'd0, "R1 count", 32'(count), 0);
    chk(size_act == 1'b0, "R1 size_act", 32'(size_act), 0);
    chk(dir_act == 1'b0, "R1 dir_act", 32'(dir_act), 0);
    chk(!err_host && !err_per, "R1 errors", {err_host, err_per}, 0);
    chk(!per_rd_valid && !host_rd_valid, "R1 valids", {per_rd_valid, host_rd_valid}, 0);
  endtask

  task automatic t_send_basic();
    logic [31:0] w [3];
    w[0] = 32'h44332211; w[1] = 32'h80FF0001; w[2] = 32'h00000000;
    for (int i = 0; i < 3; i++) hwrite(w[i], even_bit(w[i]));
    chk(count == 8'd3, "R3 count after 3 writes", 32'(count), 3);
    chk(!err_host, "R5 good parity no error", 32'(err_host), 0);
    pread_word(w[0], "R6");
    chk(count == 8'd2, "R6 word removed after lane 3", 32'(count), 2);
    pread_word(w[1], "R6");
    pread_word(w[2], "R6");
    chk(empty == 1'b1, "R3 empty after drain", 32'(empty), 1);
  endtask

  task automatic t_send_parity();
    logic [31:0] w;
    w = 32'h5A5AC3C3;
    hwrite(w, ~even_bit(w));
    chk(err_host == 1'b1, "R5 bad host parity flagged", 32'(err_host), 1);
    chk(err_per == 1'b0, "R9 other flag untouched", 32'(err_per), 0);
    tick();
    chk(err_host == 1'b1, "R9 flag sticky", 32'(err_host), 1);
    err_clr = 1'b1;
    hwrite(32'h00000001, 1'b0);
    err_clr = 1'b0;
    chk(err_host == 1'b1, "R9 set wins over clear", 32'(err_host), 1);
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk(err_host == 1'b0, "R9 clear", 32'(err_host), 0);
    pread_word(w, "R9 data unchanged");
    pread_word(32'h00000001, "R9 data unchanged");
  endtask

  task automatic t_ignored_send();
    pwrite(8'h5A, 1'b1);
    chk(count == 8'd0 && empty, "R10 peripheral write ignored in send", 32'(count), 0);
    host_rd_en = 1'b1; tick(); host_rd_en = 1'b0;
    chk(!host_rd_valid, "R10 host read ignored in send", 32'(host_rd_valid), 0);
    per_rd_en = 1'b1; tick(); per_rd_en = 1'b0;
    chk(!per_rd_valid, "R10 read of empty ignored", 32'(per_rd_valid), 0);
  endtask

  task automatic t_compat_cap();
    for (int i = 0; i < 21; i++) hwrite(pat(i), even_bit(pat(i)));
    chk(!full && count == 8'd21, "R2 not full at 21", 32'(count), 21);
    hwrite(pat(21), even_bit(pat(21)));
    chk(full && count == 8'd22, "R2 full at 22", {full, count}, {1'b1, 8'd22});
    hwrite(32'hDEADBEEF, even_bit(32'hDEADBEEF));
    chk(count == 8'd22, "R2 write when full dropped", 32'(count), 22);
    for (int i = 0; i < 22; i++) pread_word(pat(i), "R2 compat drain");
    chk(empty && count == 8'd0, "R2 extra word never stored", 32'(count), 0);
  endtask

  task automatic t_big_cap();
    size_big = 1'b1;
    tick();
    chk(size_act == 1'b1, "R4 size adopted when idle", 32'(size_act), 1);
    for (int i = 0; i < 134; i++) hwrite(pat(i), even_bit(pat(i)));
    chk(full && count == 8'd134, "R2 full at 134", {full, count}, {1'b1, 8'd134});
    hwrite(32'h12345678, even_bit(32'h12345678));
    chk(count == 8'd134, "R2 write when full dropped (big)", 32'(count), 134);
    for (int i = 0; i < 134; i++) pread_word(pat(i), "R2 big drain");
    chk(empty, "R2 empty after big drain", 32'(empty), 1);
  endtask

  task automatic t_size_hold();
    hwrite(32'hCAFE0123, even_bit(32'hCAFE0123));
    size_big = 1'b0;
    tick(); tick();
    chk(size_act == 1'b1, "R4 size held while occupied", 32'(size_act), 1);
    pread(8'h23, "R4"); pread(8'h01, "R4"); pread(8'hFE, "R4");
    tick();
    chk(size_act == 1'b1, "R4 size held mid-word", 32'(size_act), 1);
    pread(8'hCA, "R4");
    tick();
    chk(size_act == 1'b0, "R4 size adopted after drain", 32'(size_act), 0);
  endtask

  task automatic t_receive();
    dir_rx = 1'b1;
    tick();
    chk(dir_act == 1'b1, "R4 direction adopted", 32'(dir_act), 1);
    hwrite(32'h11111111, 1'b0);
    chk(count == 8'd0, "R10 host write ignored in receive", 32'(count), 0);
    pwrite(8'h11, odd_bit(8'h11)); pwrite(8'h22, odd_bit(8'h22));
    pwrite(8'h33, odd_bit(8'h33));
    chk(count == 8'd0, "R7 no word before 4th byte", 32'(count), 0);
    pwrite(8'h44, odd_bit(8'h44));
    chk(count == 8'd1, "R7 word stored on 4th byte", 32'(count), 1);
    pwrite(8'hF0, odd_bit(8'hF0)); pwrite(8'h0F, odd_bit(8'h0F));
    pwrite(8'h81, odd_bit(8'h81)); pwrite(8'h7E, odd_bit(8'h7E));
    chk(!err_per, "R7 good byte parity no error", 32'(err_per), 0);
    hread(32'h44332211, "R8");
    hread(32'h7E810FF0, "R8");
    chk(empty, "R8 empty after reads", 32'(empty), 1);
    pwrite(8'h3C, ~odd_bit(8'h3C));
    chk(err_per == 1'b1, "R7 bad byte parity flagged", 32'(err_per), 1);
    chk(err_host == 1'b0, "R9 host flag untouched", 32'(err_host), 0);
    pwrite(8'h01, odd_bit(8'h01)); pwrite(8'h02, odd_bit(8'h02));
    pwrite(8'h03, odd_bit(8'h03));
    hread(32'h0302013C, "R9 data unchanged");
    err_clr = 1'b1; tick(); err_clr = 1'b0;
    chk(err_per == 1'b0, "R9 clear", 32'(err_per), 0);
  endtask

  task automatic t_partial_hold();
    pwrite(8'hA1, odd_bit(8'hA1)); pwrite(8'hB2, odd_bit(8'hB2));
    dir_rx = 1'b0;
    tick(); tick(); tick();
    chk(dir_act == 1'b1, "R4 direction held with partial word", 32'(dir_act), 1);
    chk(empty && count == 8'd0, "R3 partial word not counted", 32'(count), 0);
    pwrite(8'hC3, odd_bit(8'hC3)); pwrite(8'hD4, odd_bit(8'hD4));
    chk(count == 8'd1, "R7 word completed", 32'(count), 1);
    hread(32'hD4C3B2A1, "R7");
    tick();
    chk(dir_act == 1'b0, "R4 direction adopted after drain", 32'(dir_act), 0);
  endtask

  initial begin
    repeat (4) tick();
    rst = 1'b0;
    t_reset();
    t_send_basic();
    t_send_parity();
    t_ignored_send();
    t_compat_cap();
    t_big_cap();
    t_size_hold();
    t_receive();
    t_partial_hold();
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=complete");
    end
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule